// File: doc/BRIEF.md
# Atomic-Alias Control Register Bank

This block holds the configuration and status registers of a serial-port peripheral. A bus master reaches them through a simple word bus: byte address, write enable, write data, and read data that follows the address combinationally. The serial shifter itself sits outside this block. It takes the stored control word, baud divisor and data word from dedicated outputs and reports events on a set of status-flag inputs.

Each writable register is reached through a group of four word addresses. The first replaces the value. The second clears the bits that are ones in the write data. The third sets those bits. The fourth inverts them. Firmware can therefore change single fields without a read-modify-write sequence, and without racing other code that touches the same register. The status register can be cleared by software but not set or inverted. Its flags are raised by hardware, and a hardware event wins over a software clear of the same bit in the same cycle.

Top module: `aliasRegBank`

## Requirements
- R1: After reset every register is zero, so every mapped address reads zero and the stored-value outputs are zero.
- R2: A write at a group's base address (control 0x00, data 0x20, baud 0x30, second control 0x40) replaces the register, and a read in the next cycle returns the written value.
- R3: A write at base+0x4 (clear alias) leaves the register equal to old AND NOT wdata.
- R4: A write at base+0x8 (set alias) leaves the register equal to old OR wdata.
- R5: A write at base+0xC (toggle alias) leaves the register equal to old XOR wdata.
- R6: A read at any of the four alias addresses of control, baud or second control returns the current register value.
- R7: The baud register stores only bits 8:0. Bits 31:9 always read zero, whatever value any alias writes.
- R8: Status flag k is set one cycle after hwEvent[k] is high and stays set. A write at 0x14 clears the flags selected by ones in wdata. Writes at 0x10, 0x18 and 0x1C do not change the status. The status reads at 0x10 and at 0x14.
- R9: If hwEvent[k] is high in the same cycle as a 0x14 write that clears bit k, the flag ends set.
- R10: Unmapped addresses read zero and ignore writes. These are 0x18, 0x1C and 0x24 to 0x2C, everything from 0x50 up, 0x40 to 0x4C when the second control register is disabled, and any address whose two low bits are not zero.
- R11: With HAS_CTRL2=1 a second control register with all four aliases sits at 0x40, and its value drives ctrl2Out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (7) | Byte address of the access |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data / bit mask for the alias operations |
| busRdata | output | 32 | Read data for busAddr, combinational |
| hwEvent | input | 32 | Per-bit status-flag set pulses |
| ctrlOut | output | 32 | Current control register |
| bufOut | output | 32 | Current data word |
| baudOut | output | BAUD_W (9) | Current baud divisor |
| ctrl2Out | output | 32 | Current second control register (zero when absent) |

## Verification
The alias operations are applied one after another to the same register, using masks that overlap bits that are already set and bits that are already clear. Each step is then read back through a different alias address, so a swapped clear and set decode, or a toggle that acts as a set, gives a wrong value. Writes with bits above the divisor width show that the upper baud bits never store anything. Writes to unmapped and misaligned addresses are each followed by a read of the neighbouring real registers, so a decode that aliases a hole onto a register is caught. The status tests raise two flags, clear one, and then pair a clear with a hardware event on the same bit, which separates "hardware wins" from "last write wins".

// File: rtl/aliasRegPkg.sv
package aliasRegPkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_SET    = 2'd2,
    OP_TOGGLE = 2'd3
  } aliasOp_e;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_CTRL, SRC_STAT, SRC_BUF, SRC_BAUD, SRC_CTRL2
  } readSrc_e;

  typedef struct packed {
    aliasOp_e op;
    logic     ctrlHit;
    logic     statClr;
    logic     bufHit;
    logic     baudHit;
    logic     ctrl2Hit;
    readSrc_e rdSrc;
  } strobe_t;

  function automatic logic [WORD_W-1:0] applyAlias(aliasOp_e op,
                                                   logic [WORD_W-1:0] cur,
                                                   logic [WORD_W-1:0] mask);
    case (op)
      OP_CLEAR:  return cur & ~mask;
      OP_SET:    return cur | mask;
      OP_TOGGLE: return cur ^ mask;
      default:   return mask;
    endcase
  endfunction
endpackage

// File: rtl/aliasRegCtrl.sv
module aliasRegCtrl
  import aliasRegPkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter bit HAS_CTRL2 = 1'b1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           strobe
);
  localparam int GRP_W = ADDR_W - 4;
  localparam logic [GRP_W-1:0] GRP_CTRL  = GRP_W'(0);
  localparam logic [GRP_W-1:0] GRP_STAT  = GRP_W'(1);
  localparam logic [GRP_W-1:0] GRP_BUF   = GRP_W'(2);
  localparam logic [GRP_W-1:0] GRP_BAUD  = GRP_W'(3);
  localparam logic [GRP_W-1:0] GRP_CTRL2 = GRP_W'(4);

  logic [GRP_W-1:0] groupIdx;
  logic [1:0]       aliasIdx;
  logic             aligned;
  readSrc_e         src;

  assign groupIdx = busAddr[ADDR_W-1:4];
  assign aliasIdx = busAddr[3:2];
  assign aligned  = (busAddr[1:0] == 2'b00);

  always_comb begin
    src = SRC_NONE;
    if (aligned) begin
      case (groupIdx)
        GRP_CTRL: src = SRC_CTRL;
        GRP_STAT: src = (aliasIdx[1] == 1'b0) ? SRC_STAT : SRC_NONE;
        GRP_BUF:  src = (aliasIdx == 2'd0) ? SRC_BUF : SRC_NONE;
        GRP_BAUD: src = SRC_BAUD;
        GRP_CTRL2: src = HAS_CTRL2 ? SRC_CTRL2 : SRC_NONE;
        default:  src = SRC_NONE;
      endcase
    end
  end

  always_comb begin
    strobe.op       = aliasOp_e'(aliasIdx);
    strobe.rdSrc    = src;
    strobe.ctrlHit  = busWe && (src == SRC_CTRL);
    strobe.statClr  = busWe && (src == SRC_STAT) && (aliasIdx == 2'd1);
    strobe.bufHit   = busWe && (src == SRC_BUF);
    strobe.baudHit  = busWe && (src == SRC_BAUD);
    strobe.ctrl2Hit = busWe && (src == SRC_CTRL2);
  end
endmodule

// File: rtl/aliasRegPath.sv
module aliasRegPath
  import aliasRegPkg::*;
#(
  parameter int BAUD_W    = 9,
  parameter bit HAS_CTRL2 = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [WORD_W-1:0] hwEvent,
  output logic [WORD_W-1:0] busRdata,
  output logic [WORD_W-1:0] ctrlVal,
  output logic [WORD_W-1:0] statVal,
  output logic [WORD_W-1:0] bufVal,
  output logic [BAUD_W-1:0] baudVal,
  output logic [WORD_W-1:0] ctrl2Val
);
  localparam int PAD_W = WORD_W - BAUD_W;

  logic [WORD_W-1:0] baudWide;
  logic [WORD_W-1:0] baudNext;
  logic [WORD_W-1:0] clrMask;

  assign baudWide = {{PAD_W{1'b0}}, baudVal};
  assign baudNext = applyAlias(strobe.op, baudWide, busWdata);
  assign clrMask  = strobe.statClr ? busWdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlVal <= '0;
      statVal <= '0;
      bufVal  <= '0;
      baudVal <= '0;
    end else begin
      if (strobe.ctrlHit) ctrlVal <= applyAlias(strobe.op, ctrlVal, busWdata);
      if (strobe.bufHit)  bufVal  <= busWdata;
      if (strobe.baudHit) baudVal <= baudNext[BAUD_W-1:0];
      statVal <= (statVal & ~clrMask) | hwEvent;
    end
  end

  generate
    if (HAS_CTRL2) begin : g_ctrl2
      logic [WORD_W-1:0] ctrl2Reg;
      always_ff @(posedge clk) begin
        if (!rstN) ctrl2Reg <= '0;
        else if (strobe.ctrl2Hit) ctrl2Reg <= applyAlias(strobe.op, ctrl2Reg, busWdata);
      end
      assign ctrl2Val = ctrl2Reg;
    end else begin : g_noCtrl2
      assign ctrl2Val = '0;
    end
  endgenerate

  always_comb begin
    case (strobe.rdSrc)
      SRC_CTRL:  busRdata = ctrlVal;
      SRC_STAT:  busRdata = statVal;
      SRC_BUF:   busRdata = bufVal;
      SRC_BAUD:  busRdata = baudWide;
      SRC_CTRL2: busRdata = ctrl2Val;
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/aliasRegBank.sv
module aliasRegBank
  import aliasRegPkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int BAUD_W    = 9,
  parameter bit HAS_CTRL2 = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [31:0]       hwEvent,
  output logic [31:0]       ctrlOut,
  output logic [31:0]       bufOut,
  output logic [BAUD_W-1:0] baudOut,
  output logic [31:0]       ctrl2Out
);
  strobe_t     strobe;
  logic [31:0] statVal;

  aliasRegCtrl #(.ADDR_W(ADDR_W), .HAS_CTRL2(HAS_CTRL2)) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .strobe(strobe)
  );

  aliasRegPath #(.BAUD_W(BAUD_W), .HAS_CTRL2(HAS_CTRL2)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .hwEvent(hwEvent), .busRdata(busRdata), .ctrlVal(ctrlOut),
    .statVal(statVal), .bufVal(bufOut), .baudVal(baudOut), .ctrl2Val(ctrl2Out)
  );
endmodule

// File: rtl/aliasRegChecker.sv
module aliasRegChecker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [31:0]       hwEvent,
  input logic [31:0]       ctrlOut,
  input logic [31:0]       statVal
);
  localparam int WA_W = ADDR_W - 2;
  logic [WA_W-1:0] wordAddr;
  logic            aligned;
  assign wordAddr = busAddr[ADDR_W-1:2];
  assign aligned  = (busAddr[1:0] == 2'b00);

  // R3
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && aligned && wordAddr == WA_W'(1)) |=> ctrlOut == ($past(ctrlOut) & ~$past(busWdata)));

  // R4
  ctrl_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && aligned && wordAddr == WA_W'(2)) |=> ctrlOut == ($past(ctrlOut) | $past(busWdata)));

  // R5
  ctrl_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && aligned && wordAddr == WA_W'(3)) |=> ctrlOut == ($past(ctrlOut) ^ $past(busWdata)));

  // R7
  baud_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aligned && wordAddr[WA_W-1:2] == (WA_W-2)'(3)) |-> busRdata[31:9] == 23'd0);

  // R8
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && aligned && wordAddr == WA_W'(5)) |=> (statVal & $past(statVal)) == $past(statVal));

  // R9
  stat_event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hwEvent != 32'd0) |=> (statVal & $past(hwEvent)) == $past(hwEvent));

  // R10
  hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!aligned || (wordAddr >= WA_W'(9) && wordAddr <= WA_W'(11))) |-> busRdata == 32'd0);
endmodule

bind aliasRegBank aliasRegChecker #(.ADDR_W(ADDR_W)) u_aliasRegChecker (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .hwEvent(hwEvent),
  .ctrlOut(ctrlOut), .statVal(statVal)
);

// File: tb/aliasRegBank_bench.sv
module aliasRegBank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] hwEvent = '0;
  logic [31:0] ctrlOut, bufOut, ctrl2Out;
  logic [8:0]  baudOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  aliasRegBank u_aliasRegBank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .hwEvent(hwEvent),
    .ctrlOut(ctrlOut), .bufOut(bufOut), .baudOut(baudOut), .ctrl2Out(ctrl2Out)
  );

  typedef struct packed {
    logic        we;
    logic [6:0]  waddr;
    logic [31:0] wdata;
    logic [6:0]  raddr;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{1'b1, 7'h00, 32'hA5A5_0F0F, 7'h00, 32'hA5A5_0F0F, 8'd2},  // R2
    '{1'b1, 7'h04, 32'h0000_000F, 7'h04, 32'hA5A5_0F00, 8'd3},  // R3 R6
    '{1'b1, 7'h08, 32'hF000_0000, 7'h08, 32'hF5A5_0F00, 8'd4},  // R4 R6
    '{1'b1, 7'h0C, 32'hFFFF_0000, 7'h0C, 32'h0A5A_0F00, 8'd5},  // R5 R6
    '{1'b1, 7'h30, 32'hFFFF_FFFF, 7'h30, 32'h0000_01FF, 8'd7},  // R7
    '{1'b1, 7'h34, 32'h0000_00F0, 7'h38, 32'h0000_010F, 8'd3},  // R3
    '{1'b1, 7'h38, 32'h0000_0E00, 7'h3C, 32'h0000_010F, 8'd7},  // R7
    '{1'b1, 7'h3C, 32'h0000_0101, 7'h30, 32'h0000_000E, 8'd5},  // R5
    '{1'b1, 7'h20, 32'h1234_5678, 7'h20, 32'h1234_5678, 8'd2},  // R2
    '{1'b1, 7'h24, 32'hFFFF_FFFF, 7'h24, 32'h0000_0000, 8'd10}, // R10
    '{1'b0, 7'h00, 32'h0000_0000, 7'h20, 32'h1234_5678, 8'd10}, // R10
    '{1'b1, 7'h50, 32'hFFFF_FFFF, 7'h00, 32'h0A5A_0F00, 8'd10}, // R10
    '{1'b1, 7'h01, 32'hFFFF_FFFF, 7'h00, 32'h0A5A_0F00, 8'd10}, // R10
    '{1'b1, 7'h40, 32'h0000_00FF, 7'h40, 32'h0000_00FF, 8'd11}, // R11
    '{1'b1, 7'h48, 32'h0000_FF00, 7'h44, 32'h0000_FFFF, 8'd11}, // R11
    '{1'b1, 7'h4C, 32'h0000_0F0F, 7'h4C, 32'h0000_F0F0, 8'd11}, // R11
    '{1'b1, 7'h10, 32'hFFFF_FFFF, 7'h10, 32'h0000_0000, 8'd8},  // R8
    '{1'b1, 7'h18, 32'h0000_FFFF, 7'h14, 32'h0000_0000, 8'd8}   // R8
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [6:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    busRead(7'h00, rd); check("R1 ctrl", rd, 32'h0);
    busRead(7'h30, rd); check("R1 baud", rd, 32'h0);
    busRead(7'h10, rd); check("R1 stat", rd, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    busRead(7'h40, rd); check("R1 ctrl2", rd, 32'h0);
    check("R1 ctrlOut", ctrlOut, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].we) begin
        busWrite(VECS[i].waddr, VECS[i].wdata);
      end else begin
        @(negedge clk);
      end
      busRead(VECS[i].raddr, rd);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
    end

    // R2 R7 R11: stored values on the outputs
    check("R2 ctrlOut", ctrlOut, 32'h0A5A_0F00);
    check("R2 bufOut", bufOut, 32'h1234_5678);
    check("R7 baudOut", {23'd0, baudOut}, 32'h0000_000E);
    check("R11 ctrl2Out", ctrl2Out, 32'h0000_F0F0);
    busRead(7'h7C, rd); check("R10 high hole", rd, 32'h0);
    busRead(7'h1C, rd); check("R10 stat toggle hole", rd, 32'h0);

    // R8: hardware event sets sticky flags
    @(negedge clk); hwEvent = 32'h0000_0081;
    @(negedge clk); hwEvent = 32'h0;
    busRead(7'h10, rd); check("R8 flags set", rd, 32'h0000_0081);
    @(negedge clk);
    busRead(7'h14, rd); check("R8 flags stay", rd, 32'h0000_0081);
    busWrite(7'h14, 32'h0000_0001);
    busRead(7'h10, rd); check("R8 clear one", rd, 32'h0000_0080);

    // R9: event and clear on the same bit in the same cycle
    @(negedge clk);
    busAddr = 7'h14; busWdata = 32'h0000_0080; busWe = 1'b1; hwEvent = 32'h0000_0080;
    @(negedge clk);
    busWe = 1'b0; hwEvent = 32'h0;
    busRead(7'h10, rd); check("R9 event wins", rd, 32'h0000_0080);
    busWrite(7'h14, 32'h0000_0080);
    busRead(7'h10, rd); check("R8 cleared", rd, 32'h0);

    // R1: reset again mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    busRead(7'h00, rd); check("R1 ctrl after reset", rd, 32'h0);
    check("R1 bufOut after reset", bufOut, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule